// File: doc/BRIEF.md
# SMT-partitioned return address predictor

This block is a return target stack shared by two hardware threads. While both threads are running, the storage is split into two private halves of equal size, one per thread. When one thread leaves the running state, the whole storage serves the thread that is still running as one deeper stack. Call events push a return target onto the issuing thread's stack. Return events pop the top entry and present it, one cycle later, as the predicted target together with a hit flag.

A mode controller registers the per-thread run indications and derives the two-thread or one-thread mode from them. A mode change leaves every stored entry in place. Only the interpretation of each thread's pointer changes. As a result, a return issued just after the switch to one-thread mode can pick up a target that the now idle thread wrote. A flush input clears the valid bits of one partition, or of the whole storage in one-thread mode. Filling the stack with known calls has the same effect. Either one lets the leaking and the non-leaking behaviour be compared.

Top module: `rap_smt_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pred_vld_o` is 0 and `mode_2t_o` is 0. Every entry is invalid after reset.
- R2: `mode_2t_o` becomes 1 on the clock edge after both bits of `thr_run` are high. It becomes 0 on the edge after either bit goes low. A call, return or flush in the same cycle as a `thr_run` change uses the old mode.
- R3: In two-thread mode, thread 0 reads and writes only physical entries 0 to 15 and thread 1 only entries 16 to 31. The physical index is {tid, pointer[3:0]}, and a 2T push or pop never changes bit 4 of the pointer. Traffic from one thread never changes the other thread's predictions.
- R4: In one-thread mode, the issuing thread's 5-bit pointer indexes all 32 entries directly, wrapping modulo 32. The thread therefore holds 32 returns in LIFO order.
- R5: A mode switch neither clears nor rewrites entries or pointer registers. After a switch to one-thread mode, a return can be predicted, with hit = 1, from an entry that the other thread wrote.
- R6: A return (`ret_en`=1) pops the top entry of thread `op_tid`, the most recent push not yet popped. One cycle later the entry appears on `pred_tgt_o`, with `pred_hit_o` = 1 when the thread's count is non-zero and the entry is valid.
- R7: Pushing beyond the capacity (16 in 2T, 32 in 1T) wraps and overwrites the oldest entry, and the count saturates at the capacity. A pop at count 0 still moves the pointer and returns the addressed entry, with `pred_hit_o` = 0.
- R8: A flush (`flush_en`=1) clears the valid bits of the half selected by `flush_tid` in 2T mode, or of all entries in 1T mode. A pop in the same cycle sees the valid bits from before the flush. A push in the same cycle leaves its own entry valid.
- R9: Calls and returns from a thread whose registered run bit is 0 are ignored. When `call_en` and `ret_en` are both high, only the return is performed.
- R10: `pred_vld_o` pulses for exactly one cycle, the cycle after each accepted return, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_run | input | 2 | Per-thread running indication (1 = running) |
| call_en | input | 1 | Call event: push `call_tgt` for `op_tid` |
| ret_en | input | 1 | Return event: pop a prediction for `op_tid` |
| op_tid | input | 1 | Thread issuing the call or return |
| call_tgt | input | AW | Return target pushed by a call |
| flush_en | input | 1 | Invalidate the partition selected by `flush_tid` |
| flush_tid | input | 1 | Thread whose half is flushed in 2T mode |
| pred_vld_o | output | 1 | Prediction strobe, one cycle after an accepted return |
| pred_hit_o | output | 1 | Predicted target is valid |
| pred_tgt_o | output | AW | Predicted return target |
| mode_2t_o | output | 1 | 1 = two-thread split mode, 0 = one-thread mode |

## Verification
Several directed patterns are driven first. One pushes from both threads in split mode and then drops thread 0. The pop that follows returns thread 0's data with the hit flag set, which separates a correct pointer reinterpretation from a design that clears or remaps on a switch. The same sequence is repeated with a flush before the pop, which tells a valid-bit flush apart from a pointer-only reset. A run of 17 pushes in split mode and a run of 20 in single mode show whether the wrap point sits at 16 or at 32. Random mixes of calls, returns, flushes and run changes from a fixed seed are then compared against a bench model of the two pointers, the counts and the valid bits.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef enum logic {
    MODE_1T = 1'b0,
    MODE_2T = 1'b1
  } rap_mode_e;
endpackage

// File: rtl/rap_mode_ctl.sv
module rap_mode_ctl
  import rap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] run_i,
  output logic [1:0] run_q_o,
  output rap_mode_e  mode_o
);
  logic [1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 2'b00;
    else     run_q <= run_i;
  end

  assign run_q_o = run_q;
  assign mode_o  = (&run_q) ? MODE_2T : MODE_1T;
endmodule

// File: rtl/rap_ptr_unit.sv
module rap_ptr_unit
  import rap_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TID   = 0,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  rap_mode_e     mode_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          cnt_nz_o,
  output logic [CW-1:0] cnt_o
);
  localparam int  HALF = DEPTH / 2;
  localparam logic HI  = (TID != 0);

  logic [PW-1:0] ptr_q, ptr_inc, ptr_dec, nxt_up, nxt_dn;
  logic [CW-1:0] cnt_q, cap;

  always_comb begin
    ptr_inc = ptr_q + 1'b1;
    ptr_dec = ptr_q - 1'b1;
    if (mode_i == MODE_2T) begin
      // split mode: high pointer bit is frozen, low bits wrap in the half
      nxt_up   = {ptr_q[PW-1], ptr_inc[PW-2:0]};
      nxt_dn   = {ptr_q[PW-1], ptr_dec[PW-2:0]};
      wr_idx_o = {HI, ptr_q[PW-2:0]};
      rd_idx_o = {HI, ptr_dec[PW-2:0]};
      cap      = CW'(HALF);
    end else begin
      nxt_up   = ptr_inc;
      nxt_dn   = ptr_dec;
      wr_idx_o = ptr_q;
      rd_idx_o = ptr_dec;
      cap      = CW'(DEPTH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= nxt_up;
      if (cnt_q < cap) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      ptr_q <= nxt_dn;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_nz_o = (cnt_q != '0);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/rap_store.sv
module rap_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [PW-1:0]    widx_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [PW-1:0]    ridx_i,
  input  logic             clr_i,
  input  logic [DEPTH-1:0] clr_mask_i,
  output logic [AW-1:0]    rdata_o,
  output logic             rvld_o
);
  logic [AW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vbit_q, vbit_n;

  // target array: single write port, registered read, no reset
  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
    if (re_i) rdata_o <= mem[ridx_i];
  end

  always_comb begin
    vbit_n = vbit_q;
    if (clr_i) vbit_n = vbit_n & ~clr_mask_i;
    if (we_i)  vbit_n[widx_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbit_q <= '0;
      rvld_o <= 1'b0;
    end else begin
      vbit_q <= vbit_n;
      if (re_i) rvld_o <= vbit_q[ridx_i];
    end
  end
endmodule

// File: rtl/rap_smt_top.sv
module rap_smt_top
  import rap_pkg::*;
#(
  parameter int AW   = 32,
  parameter int HALF = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    thr_run,
  input  logic          call_en,
  input  logic          ret_en,
  input  logic          op_tid,
  input  logic [AW-1:0] call_tgt,
  input  logic          flush_en,
  input  logic          flush_tid,
  output logic          pred_vld_o,
  output logic          pred_hit_o,
  output logic [AW-1:0] pred_tgt_o,
  output logic          mode_2t_o
);
  localparam int DEPTH = 2 * HALF;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;

  rap_mode_e            mode;
  logic [1:0]           run_q;
  logic                 op_ok, do_pop, do_push;
  logic [PW-1:0]        wr_idx [2];
  logic [PW-1:0]        rd_idx [2];
  logic [1:0]           cnt_nz;
  logic [1:0][CW-1:0]   thr_cnt;
  logic                 st_we;
  logic [PW-1:0]        st_widx, st_ridx;
  logic [DEPTH-1:0]     clr_mask;
  logic                 vld_q, cnt_hit_q, ent_vld;

  rap_mode_ctl u_mode (
    .clk     (clk),
    .rst     (rst),
    .run_i   (thr_run),
    .run_q_o (run_q),
    .mode_o  (mode)
  );

  assign op_ok   = run_q[op_tid];
  assign do_pop  = ret_en & op_ok;
  assign do_push = call_en & ~ret_en & op_ok;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    rap_ptr_unit #(.DEPTH(DEPTH), .TID(t)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .mode_i   (mode),
      .push_i   (do_push & (op_tid == 1'(t))),
      .pop_i    (do_pop & (op_tid == 1'(t))),
      .wr_idx_o (wr_idx[t]),
      .rd_idx_o (rd_idx[t]),
      .cnt_nz_o (cnt_nz[t]),
      .cnt_o    (thr_cnt[t])
    );
  end

  assign st_we   = do_push;
  assign st_widx = wr_idx[op_tid];
  assign st_ridx = rd_idx[op_tid];

  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    localparam logic UPPER = (i >= HALF);
    assign clr_mask[i] = (mode == MODE_1T) || (UPPER == flush_tid);
  end

  rap_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst        (rst),
    .we_i       (st_we),
    .widx_i     (st_widx),
    .wdata_i    (call_tgt),
    .re_i       (do_pop),
    .ridx_i     (st_ridx),
    .clr_i      (flush_en),
    .clr_mask_i (clr_mask),
    .rdata_o    (pred_tgt_o),
    .rvld_o     (ent_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      cnt_hit_q <= 1'b0;
    end else begin
      vld_q <= do_pop;
      if (do_pop) cnt_hit_q <= cnt_nz[op_tid];
    end
  end

  assign pred_vld_o = vld_q;
  assign pred_hit_o = vld_q & cnt_hit_q & ent_vld;
  assign mode_2t_o  = (mode == MODE_2T);
endmodule

// File: rtl/rap_smt_chk.sv
module rap_smt_chk #(
  parameter int AW   = 32,
  parameter int HALF = 16,
  localparam int DEPTH = 2 * HALF,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         thr_run,
  input logic               ret_en,
  input logic               op_tid,
  input logic               pred_vld_o,
  input logic               pred_hit_o,
  input logic               mode_2t_o,
  input logic               st_we,
  input logic [PW-1:0]      st_widx,
  input logic [1:0][CW-1:0] thr_cnt
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_vld_o);

  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_2t_o == $past(&thr_run)));

  // R3
  split_half_chk: assert property (@(posedge clk) disable iff (rst)
    (st_we && mode_2t_o) |-> (st_widx[PW-1] == op_tid));

  // R6
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pred_hit_o |-> pred_vld_o);

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_cnt[0] <= CW'(DEPTH)) && (thr_cnt[1] <= CW'(DEPTH)));

  // R10
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    pred_vld_o |-> $past(ret_en));
endmodule

bind rap_smt_top rap_smt_chk #(.AW(AW), .HALF(HALF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thr_run    (thr_run),
  .ret_en     (ret_en),
  .op_tid     (op_tid),
  .pred_vld_o (pred_vld_o),
  .pred_hit_o (pred_hit_o),
  .mode_2t_o  (mode_2t_o),
  .st_we      (st_we),
  .st_widx    (st_widx),
  .thr_cnt    (thr_cnt)
);

// File: tb/rap_smt_top_tb_top.sv
module rap_smt_top_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW     = 32;
  localparam int HALF   = 16;
  localparam int DEPTH  = 2 * HALF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    thr_run = 2'b00;
  logic          call_en = 1'b0, ret_en = 1'b0, op_tid = 1'b0;
  logic [AW-1:0] call_tgt = '0;
  logic          flush_en = 1'b0, flush_tid = 1'b0;
  logic          pred_vld_o, pred_hit_o, mode_2t_o;
  logic [AW-1:0] pred_tgt_o;

  rap_smt_top #(.AW(AW), .HALF(HALF)) dut_i (.*);

  always #(CLK_NS / 2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [AW-1:0] m_mem [DEPTH];
  bit            m_wr  [DEPTH];
  bit            m_vb  [DEPTH];
  int            m_p   [2];
  int            m_cnt [2];
  logic [1:0]    m_run;

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pmove(int p, int d, bit two);
    if (two) return (p & HALF) | ((p + d + HALF) % HALF);
    return (p + d + DEPTH) % DEPTH;
  endfunction

  function automatic int phys(int t, int p, bit two);
    if (two) return t * HALF + (p % HALF);
    return p;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin m_wr[i] = 0; m_vb[i] = 0; m_mem[i] = '0; end
    for (int t = 0; t < 2; t++) begin m_p[t] = 0; m_cnt[t] = 0; end
    m_run = 2'b00;
  endtask

  task automatic do_reset();
    rst = 1'b1; thr_run = 2'b00; call_en = 0; ret_en = 0; flush_en = 0;
    model_clear();
    repeat (2) @(negedge clk);
    chk(pred_vld_o == 1'b0, "R1 strobe in reset", pred_vld_o, 0);
    chk(mode_2t_o == 1'b0, "R1 mode in reset", mode_2t_o, 0);
    rst = 1'b0;
  endtask

  task automatic step(logic [1:0] run, bit call, bit ret, bit tid,
                      logic [AW-1:0] tgt, bit fl, bit ftid);
    bit two, ok, pop, push, e_hit, e_known;
    int pm, ridx, widx;
    logic [AW-1:0] e_addr;
    thr_run = run; call_en = call; ret_en = ret; op_tid = tid;
    call_tgt = tgt; flush_en = fl; flush_tid = ftid;
    two = (m_run == 2'b11); ok = m_run[tid];
    pop = ret && ok; push = call && !ret && ok;
    e_hit = 0; e_known = 0; e_addr = '0; pm = 0;
    if (pop) begin
      pm = pmove(m_p[tid], -1, two);
      ridx = phys(tid, pm, two);
      e_hit = (m_cnt[tid] > 0) && m_vb[ridx];
      e_addr = m_mem[ridx]; e_known = m_wr[ridx];
    end
    if (fl) for (int i = 0; i < DEPTH; i++)
      if (!two || (i / HALF) == int'(ftid)) m_vb[i] = 0;
    if (push) begin
      widx = phys(tid, m_p[tid], two);
      m_mem[widx] = tgt; m_vb[widx] = 1; m_wr[widx] = 1;
      m_p[tid] = pmove(m_p[tid], 1, two);
      if (m_cnt[tid] < (two ? HALF : DEPTH)) m_cnt[tid]++;
    end else if (pop) begin
      m_p[tid] = pm;
      if (m_cnt[tid] > 0) m_cnt[tid]--;
    end
    m_run = run;
    @(negedge clk);
    call_en = 0; ret_en = 0; flush_en = 0;
    chk(pred_vld_o == pop, "R10 strobe", pred_vld_o, pop);
    if (pop) begin
      chk(pred_hit_o == e_hit, "R6 hit flag", pred_hit_o, e_hit);
      if (e_known) chk(pred_tgt_o == e_addr, "R6 target", pred_tgt_o, e_addr);
    end
    chk(mode_2t_o == (m_run == 2'b11), "R2 mode", mode_2t_o, m_run == 2'b11);
  endtask

  initial begin
    logic [AW-1:0] got;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset();

    // R1: entries invalid after reset
    step(2'b11, 0, 0, 0, '0, 0, 0);
    step(2'b11, 0, 1, 1, '0, 0, 0);
    chk(pred_hit_o == 0, "R1 empty after reset", pred_hit_o, 0);

    // R5: leak after switch to 1T
    do_reset();
    step(2'b11, 0, 0, 0, '0, 0, 0);
    for (int k = 0; k < 4; k++) step(2'b11, 1, 0, 0, 32'hA00 + k, 0, 0);
    step(2'b11, 1, 0, 1, 32'hB00, 0, 0);
    step(2'b11, 1, 0, 1, 32'hB01, 0, 0);
    // R3: thread 1 top is its own entry in split mode
    step(2'b11, 0, 1, 1, '0, 0, 0);
    chk(pred_tgt_o == 32'hB01, "R3 private half", pred_tgt_o, 32'hB01);
    step(2'b11, 1, 0, 1, 32'hB01, 0, 0);
    // R2: op in switching cycle uses old mode
    step(2'b10, 1, 0, 0, 32'hA04, 0, 0);
    chk(mode_2t_o == 0, "R2 leave 2T", mode_2t_o, 0);
    step(2'b10, 0, 1, 1, '0, 0, 0);
    chk(pred_hit_o == 1, "R5 leak hit", pred_hit_o, 1);
    chk(pred_tgt_o == 32'hA01, "R5 leak target", pred_tgt_o, 32'hA01);

    // R8: flush in 1T removes the leak
    do_reset();
    step(2'b11, 0, 0, 0, '0, 0, 0);
    for (int k = 0; k < 4; k++) step(2'b11, 1, 0, 0, 32'hA00 + k, 0, 0);
    step(2'b11, 1, 0, 1, 32'hB00, 0, 0);
    step(2'b11, 1, 0, 1, 32'hB01, 0, 0);
    step(2'b10, 0, 0, 0, '0, 0, 0);
    step(2'b10, 0, 0, 0, '0, 1, 1);
    step(2'b10, 0, 1, 1, '0, 0, 0);
    chk(pred_hit_o == 0, "R8 flush 1T", pred_hit_o, 0);

    // R8: flush of half 0 in 2T spares thread 1
    do_reset();
    step(2'b11, 0, 0, 0, '0, 0, 0);
    step(2'b11, 1, 0, 0, 32'hC00, 0, 0);
    step(2'b11, 1, 0, 1, 32'hD00, 0, 0);
    step(2'b11, 0, 0, 0, '0, 1, 0);
    step(2'b11, 0, 1, 1, '0, 0, 0);
    chk(pred_hit_o == 1, "R8 other half kept", pred_hit_o, 1);
    step(2'b11, 0, 1, 0, '0, 0, 0);
    chk(pred_hit_o == 0, "R8 own half cleared", pred_hit_o, 0);

    // R7: wrap at 16 in 2T
    do_reset();
    step(2'b11, 0, 0, 0, '0, 0, 0);
    for (int k = 0; k < 17; k++) step(2'b11, 1, 0, 0, 32'hE00 + k, 0, 0);
    step(2'b11, 0, 1, 0, '0, 0, 0);
    chk(pred_tgt_o == 32'hE10, "R7 newest first", pred_tgt_o, 32'hE10);
    for (int k = 0; k < 15; k++) step(2'b11, 0, 1, 0, '0, 0, 0);
    chk(pred_tgt_o == 32'hE01 && pred_hit_o, "R7 oldest kept", pred_tgt_o, 32'hE01);
    step(2'b11, 0, 1, 0, '0, 0, 0);
    chk(pred_hit_o == 0, "R7 underflow", pred_hit_o, 0);

    // R4: 32 deep in 1T
    do_reset();
    step(2'b01, 0, 0, 0, '0, 0, 0);
    for (int k = 0; k < 20; k++) step(2'b01, 1, 0, 0, 32'hF00 + k, 0, 0);
    got = '0;
    for (int k = 0; k < 20; k++) begin
      step(2'b01, 0, 1, 0, '0, 0, 0);
      got = pred_tgt_o;
    end
    chk(got == 32'hF00 && pred_hit_o, "R4 deep stack", got, 32'hF00);

    // R9: idle thread and call+return collision
    step(2'b01, 1, 0, 0, 32'h123, 0, 0);
    step(2'b01, 1, 0, 1, 32'h999, 0, 0);
    step(2'b01, 0, 1, 1, '0, 0, 0);
    chk(pred_vld_o == 0, "R9 idle ignored", pred_vld_o, 0);
    step(2'b01, 1, 1, 0, 32'h456, 0, 0);
    chk(pred_tgt_o == 32'h123, "R9 return wins", pred_tgt_o, 32'h123);
    step(2'b01, 0, 1, 0, '0, 0, 0);
    chk(pred_hit_o == 0, "R9 call dropped", pred_hit_o, 0);

    // random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] run;
      int r;
      r = $urandom % 40;
      if (n == 0 || r == 0) begin
        r = $urandom % 4;
        run = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : 2'b11;
      end else run = m_run;
      r = $urandom % 100;
      step(run, r < 45, r >= 45 && r < 85 || r >= 97, 1'($urandom),
           $urandom, ($urandom % 50) == 0, 1'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule